// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a small five-register window through which it reaches a much larger internal register space. The host never addresses the internal registers directly. It stages a target address and, for writes, the data to store. It then writes a command word whose top bits select a write or a read.

A change of the command word from zero to a nonzero value with a request bit set makes the bridge issue one single-cycle request on its internal register port. The internal side may take any number of cycles before it acknowledges. On the acknowledge the bridge captures read data (for reads only) and raises its done flag. The host polls the done register, fetches the read result, and writes zero to the command word, which clears done and re-arms the bridge for the next access.

Host reads are combinational from the host offset. Host writes take effect at the clock edge on which `host_sel` and `host_wr` are both high.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset every window register reads 0 (target address 0x00, command 0x04, write data 0x08, read data 0x0C, done 0x10) and `int_req` is low.
- R2: Host writes to offsets 0x00, 0x04 and 0x08 are read back unchanged at the same offsets. Offsets 0x14 to 0x1C read 0.
- R3: A command write that moves the command word from 0 to a value with bit 31 set produces exactly one `int_req` pulse, one cycle long, in the cycle after that write. During the pulse `int_we` is 1, `int_addr` equals the low `IADDR_W` bits of the target address, and `int_wdata` equals the write-data register.
- R4: A command that moves the word from 0 to a value with bit 30 set and bit 31 clear produces one request with `int_we` at 0. The `int_rdata` value present with `int_ack` is then returned at offset 0x0C.
- R5: Offset 0x10 reads 1 (bit 0) only after the internal acknowledge of the current access has been sampled. Before that it reads 0, whatever the acknowledge latency, including zero.
- R6: Writing 0 to the command word clears the done register to 0 at once.
- R7: Writing another nonzero value to the command word while it is already nonzero starts no further request and leaves done unchanged.
- R8: A command with both bit 31 and bit 30 set runs a single write access (`int_we` = 1) and no read.
- R9: Host writes to offsets 0x0C and 0x10 have no effect, and a write access leaves the read-data register unchanged.
- R10: A nonzero command with neither bit 31 nor bit 30 set starts no request, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | HOST_AW | Host byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Window register selected by host_addr |
| int_req | output | 1 | Single-cycle internal access request |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | IADDR_W | Internal register address |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Internal access completed |
| int_rdata | input | 32 | Internal read data, valid with int_ack |

## Verification
The assertions assume the internal side returns exactly one `int_ack` for each request and never acknowledges when no access is outstanding. They also assume the host does not clear or rewrite the command word while an access is still in flight. The bench's register model responds once per request, after a latency chosen by each scenario. Every scenario polls done before it writes zero to the command word, so the stimulus stays within these assumptions.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int DW         = 32;
    localparam int OFS_TADDR  = 'h00;
    localparam int OFS_CMD    = 'h04;
    localparam int OFS_WDAT   = 'h08;
    localparam int OFS_RDAT   = 'h0C;
    localparam int OFS_DONE   = 'h10;
    localparam int CMD_WR_BIT = 31;
    localparam int CMD_RD_BIT = 30;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } sq_state_e;

    typedef struct packed {
        logic [DW-1:0] taddr;
        logic [DW-1:0] cmd;
        logic [DW-1:0] wdat;
    } win_regs_t;

    typedef struct packed {
        sq_state_e     st;
        logic          req;
        logic          we;
        logic          done;
        logic [DW-1:0] rdat;
    } seq_regs_t;

    // The write bit outranks the read bit.
    function automatic op_e decode_cmd(input logic [DW-1:0] c);
        if (c[CMD_WR_BIT])      return OP_WRITE;
        else if (c[CMD_RD_BIT]) return OP_READ;
        else                    return OP_NONE;
    endfunction

endpackage

// File: rtl/ibr_window.sv
module ibr_window
    import ibr_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      taddr_o,
    output logic [DW-1:0]      cmd_o,
    output logic [DW-1:0]      wdat_o,
    output logic               start_o,
    output op_e                start_op_o,
    output logic               clr_o
);

    localparam logic [HOST_AW-1:0] A_TADDR = HOST_AW'(OFS_TADDR);
    localparam logic [HOST_AW-1:0] A_CMD   = HOST_AW'(OFS_CMD);
    localparam logic [HOST_AW-1:0] A_WDAT  = HOST_AW'(OFS_WDAT);

    win_regs_t r_d, r_q;
    op_e       op_d;

    always_comb begin
        r_d     = r_q;
        op_d    = decode_cmd(wr_data);
        start_o = 1'b0;
        clr_o   = 1'b0;
        if (wr_en) begin
            if (wr_addr == A_TADDR) begin
                r_d.taddr = wr_data;
            end else if (wr_addr == A_CMD) begin
                r_d.cmd = wr_data;
                if (wr_data == '0) begin
                    clr_o = 1'b1;
                end else if ((r_q.cmd == '0) && (op_d != OP_NONE)) begin
                    // only a zero-to-nonzero edge launches an access
                    start_o = 1'b1;
                end
            end else if (wr_addr == A_WDAT) begin
                r_d.wdat = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign taddr_o    = r_q.taddr;
    assign cmd_o      = r_q.cmd;
    assign wdat_o     = r_q.wdat;
    assign start_op_o = op_d;

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  op_e           start_op_i,
    input  logic          clr_i,
    input  logic          ack_i,
    input  logic [DW-1:0] ack_data_i,
    output logic          req_o,
    output logic          we_o,
    output logic          done_o,
    output logic          busy_o,
    output logic [DW-1:0] rdat_o
);

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (clr_i) s_d.done = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.st   = SQ_WAIT;
                    s_d.req  = 1'b1;
                    s_d.we   = (start_op_i == OP_WRITE);
                    s_d.done = 1'b0;
                end
            end
            SQ_WAIT: begin
                if (ack_i) begin
                    s_d.st   = SQ_IDLE;
                    s_d.done = 1'b1;
                    if (!s_q.we) s_d.rdat = ack_data_i;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, req: 1'b0, we: 1'b0, done: 1'b0, rdat: '0};
        else        s_q <= s_d;
    end

    assign req_o  = s_q.req;
    assign we_o   = s_q.we;
    assign done_o = s_q.done;
    assign busy_o = (s_q.st == SQ_WAIT);
    assign rdat_o = s_q.rdat;

endmodule

// File: rtl/ibr_rdmux.sv
module ibr_rdmux
    import ibr_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic [HOST_AW-1:0] sel_addr,
    input  logic [DW-1:0]      taddr,
    input  logic [DW-1:0]      cmd,
    input  logic [DW-1:0]      wdat,
    input  logic [DW-1:0]      rdat,
    input  logic               done,
    output logic [DW-1:0]      rdata_o
);

    always_comb begin
        rdata_o = '0;
        if      (sel_addr == HOST_AW'(OFS_TADDR)) rdata_o = taddr;
        else if (sel_addr == HOST_AW'(OFS_CMD))   rdata_o = cmd;
        else if (sel_addr == HOST_AW'(OFS_WDAT))  rdata_o = wdat;
        else if (sel_addr == HOST_AW'(OFS_RDAT))  rdata_o = rdat;
        else if (sel_addr == HOST_AW'(OFS_DONE))  rdata_o = {{(DW-1){1'b0}}, done};
    end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int HOST_AW = 5,
    parameter int IADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               int_req,
    output logic               int_we,
    output logic [IADDR_W-1:0] int_addr,
    output logic [DW-1:0]      int_wdata,
    input  logic               int_ack,
    input  logic [DW-1:0]      int_rdata
);

    logic [DW-1:0] taddr_q, cmd_q, wdat_q, rdat_q;
    logic          start, clr, busy, done_flag;
    op_e           start_op;

    ibr_window #(.HOST_AW(HOST_AW)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_sel && host_wr),
        .wr_addr   (host_addr),
        .wr_data   (host_wdata),
        .taddr_o   (taddr_q),
        .cmd_o     (cmd_q),
        .wdat_o    (wdat_q),
        .start_o   (start),
        .start_op_o(start_op),
        .clr_o     (clr)
    );

    ibr_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .start_op_i(start_op),
        .clr_i     (clr),
        .ack_i     (int_ack),
        .ack_data_i(int_rdata),
        .req_o     (int_req),
        .we_o      (int_we),
        .done_o    (done_flag),
        .busy_o    (busy),
        .rdat_o    (rdat_q)
    );

    ibr_rdmux #(.HOST_AW(HOST_AW)) i_rdmux (
        .sel_addr(host_addr),
        .taddr   (taddr_q),
        .cmd     (cmd_q),
        .wdat    (wdat_q),
        .rdat    (rdat_q),
        .done    (done_flag),
        .rdata_o (host_rdata)
    );

    assign int_addr  = taddr_q[IADDR_W-1:0];
    assign int_wdata = wdat_q;

endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk
    import ibr_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_sel,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [DW-1:0]      host_wdata,
    input logic               int_req,
    input logic               int_we,
    input logic               int_ack,
    input logic [DW-1:0]      cmd_q,
    input logic               busy,
    input logic               done_flag
);

    logic cmd_zero_wr;
    assign cmd_zero_wr = host_sel && host_wr &&
                         (host_addr == HOST_AW'(OFS_CMD)) && (host_wdata == '0);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req); // R3

    AST_REQ_FROM_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ($past(cmd_q) == '0)); // R7

    AST_WRITE_OUTRANKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_we == cmd_q[CMD_WR_BIT])); // R8

    AST_DONE_ON_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(int_ack)); // R5

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_zero_wr && !(busy && int_ack)) |=> !done_flag); // R6

    AST_REQ_NEEDS_REQ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (cmd_q[CMD_WR_BIT] || cmd_q[CMD_RD_BIT])); // R10

endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.HOST_AW(HOST_AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .int_req   (int_req),
    .int_we    (int_we),
    .int_ack   (int_ack),
    .cmd_q     (cmd_q),
    .busy      (busy),
    .done_flag (done_flag)
);

// File: tb/test_ind_reg_bridge.sv
`timescale 1ns/1ps
module test_ind_reg_bridge;

    localparam int HOST_AW = 5;
    localparam int IADDR_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_sel = 1'b0;
    logic               host_wr = 1'b0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [31:0]        host_wdata = '0;
    logic [31:0]        host_rdata;
    logic               int_req, int_we;
    logic [IADDR_W-1:0] int_addr;
    logic [31:0]        int_wdata;
    logic               int_ack = 1'b0;
    logic [31:0]        int_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // internal register model
    logic [31:0]        mem [16];
    int                 lat = 1;
    int                 req_cnt = 0;
    logic               last_we;
    logic [IADDR_W-1:0] last_addr;
    logic [31:0]        last_wdata;

    always #2.5 clk = ~clk;

    ind_reg_bridge #(.HOST_AW(HOST_AW), .IADDR_W(IADDR_W)) i_ind_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_ack(int_ack), .int_rdata(int_rdata)
    );

    always @(negedge clk) if (rst_n && int_req) req_cnt <= req_cnt + 1;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h5A00_0000 + i * 32'h0001_0203;
        forever begin
            @(negedge clk);
            if (rst_n && int_req) begin
                last_we    = int_we;
                last_addr  = int_addr;
                last_wdata = int_wdata;
                repeat (lat) @(negedge clk);
                int_ack = 1'b1;
                if (last_we) mem[last_addr[3:0]] = last_wdata;
                else         int_rdata = mem[last_addr[3:0]];
                @(negedge clk);
                int_ack   = 1'b0;
                int_rdata = 32'hDEAD_0BAD;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = HOST_AW'(a); host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [31:0] d);
        host_addr = HOST_AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic poll_done(output logic [31:0] d);
        d = 0;
        for (int k = 0; k < 40 && d == 0; k++) begin
            @(negedge clk);
            host_read('h10, d);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a <= 'h10; a += 4) begin
            host_read(a, v);
            check("R1 reset value", v, 32'h0);
        end
        check("R1 no request", {31'b0, int_req}, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        host_write('h00, 32'h1234_5678);
        host_write('h08, 32'hCAFE_F00D);
        host_read('h00, v); check("R2 target address", v, 32'h1234_5678);
        host_read('h08, v); check("R2 write data", v, 32'hCAFE_F00D);
        host_read('h14, v); check("R2 unmapped 0x14", v, 32'h0);
        host_read('h1C, v); check("R2 unmapped 0x1C", v, 32'h0);
    endtask

    task automatic t_write(input logic [31:0] a, input logic [31:0] d, input int l,
                           input logic [31:0] cmd, input string tag);
        logic [31:0] v, rd_before;
        int c0;
        lat = l;
        host_read('h0C, rd_before);
        host_write('h00, a);
        host_write('h08, d);
        c0 = req_cnt;
        host_write('h04, cmd);
        if (l >= 2) begin
            host_read('h10, v); check("R5 done low before ack", v, 32'h0);
        end
        poll_done(v);
        check("R5 done after ack", v, 32'h1);
        check({tag, " one request"}, req_cnt - c0, 32'd1);
        check({tag, " write flag"}, {31'b0, last_we}, 32'h1);
        check("R3 internal address", {16'b0, last_addr}, {16'b0, a[15:0]});
        check("R3 internal data", last_wdata, d);
        host_read('h0C, v); check("R9 read data kept on write", v, rd_before);
        host_write('h04, 32'h0);
        host_read('h10, v); check("R6 done cleared", v, 32'h0);
    endtask

    task automatic t_read(input logic [31:0] a, input int l);
        logic [31:0] v;
        int c0;
        lat = l;
        host_write('h00, a);
        c0 = req_cnt;
        host_write('h04, 32'h4000_0000);
        if (l >= 2) begin
            host_read('h10, v); check("R5 done low before ack", v, 32'h0);
        end
        poll_done(v);
        check("R5 done after ack", v, 32'h1);
        check("R4 one request", req_cnt - c0, 32'd1);
        check("R4 read flag", {31'b0, last_we}, 32'h0);
        host_read('h0C, v); check("R4 read data", v, mem[a[3:0]]);
        host_write('h04, 32'h0);
        host_read('h10, v); check("R6 done cleared", v, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        int c0;
        lat = 1;
        host_write('h00, 32'h0000_0003);
        host_write('h04, 32'h4000_0000);
        poll_done(v);
        c0 = req_cnt;
        host_write('h04, 32'h8000_0000);
        host_write('h04, 32'h4000_0001);
        repeat (6) @(negedge clk);
        check("R7 no repeat request", req_cnt - c0, 32'd0);
        host_read('h10, v); check("R7 done unchanged", v, 32'h1);
        host_write('h04, 32'h0);
    endtask

    task automatic t_ignored;
        logic [31:0] v, rd0;
        host_read('h0C, rd0);
        host_write('h0C, 32'hFFFF_FFFF);
        host_write('h10, 32'hFFFF_FFFF);
        host_read('h0C, v); check("R9 read data not writable", v, rd0);
        host_read('h10, v); check("R9 done not writable", v, 32'h0);
    endtask

    task automatic t_nobits;
        logic [31:0] v;
        int c0;
        c0 = req_cnt;
        host_write('h04, 32'h0000_0001);
        repeat (8) @(negedge clk);
        check("R10 no request", req_cnt - c0, 32'd0);
        host_read('h10, v); check("R10 done stays low", v, 32'h0);
        host_write('h04, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_readback;
        t_write(32'hABCD_0005, 32'h1111_2222, 4, 32'h8000_0000, "R3");
        t_read(32'h0000_0005, 3);
        t_read(32'h0000_000A, 0);
        t_write(32'h0000_0009, 32'h7654_3210, 0, 32'h8000_0000, "R3");
        t_read(32'h0000_0009, 1);
        t_write(32'h0000_000C, 32'h0F0F_0F0F, 2, 32'hC000_0000, "R8");
        t_read(32'h0000_000C, 5);
        t_hold;
        t_ignored;
        t_nobits;
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule